// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block drives the external memory bus of a small 8-bit controller. On that bus the low address byte and the data byte share one 8-bit port. It runs three kinds of cycle: code fetch, data read and data write. For each cycle it produces the following outputs:

- an active-high address latch strobe;
- an active-low code-fetch strobe;
- active-low read and write strobes;
- the shared-port output value and its output enable;
- the high address byte.

For fetches and reads it captures the byte presented on the shared port.

All timing counts periods of an input tick. The tick marks one oscillator period. A period is the interval between two clocks on which `osc_tick` is high. A requester presents a cycle kind, a 16-bit address and write data. The block takes the request only on a tick, and only while it is idle or in the last period of the current cycle. When the cycle ends, a one-clock done pulse returns the captured byte.

Top module: `mxb_bus_gen`

## Requirements
- R1: After reset, and whenever no cycle is active, the outputs sit at their idle values: `ale` 0, `psen_n`, `rd_n` and `wr_n` 1, `ad_oe` 0, `ad_out` 0, `done` 0 and `req_ready` 1.
- R2: Periods of a cycle are numbered from phase 0, the period that starts at the accepting tick, and the phase advances only on clocks with `osc_tick` high. `ale` is high in phases 0 and 1 and low in every later phase.
- R3: The port drives the low address byte in phases 1 and 2, that is one period before `ale` falls and one period after. `a_hi` shows the high address byte from the clock after acceptance and keeps it until the next accepted cycle.
- R4: Kind code 0 (fetch) holds `psen_n` low in phases 3 to 5 and lasts 6 periods. `rd_n` and `wr_n` stay high during a fetch.
- R5: Kind code 1 (read) holds `rd_n` low in phases 5 to 10 and lasts 12 periods. The port is not driven from phase 3 to phase 11, nor in phase 0 of the next cycle.
- R6: Kind code 2 (write) holds `wr_n` low in phases 5 to 10 and lasts 12 periods. The port drives the write byte in phases 4 to 11.
- R7: `rdata` takes the value of `ad_in` at the tick that ends the last low period of the strobe (fetch phase 5, read phase 10). `done` is high for exactly the one clock after the tick that ends a cycle. A write leaves `rdata` unchanged.
- R8: A request is taken on a clock where `osc_tick`, `req_valid` and `req_ready` are all high. `req_ready` is high when the block is idle or in the final phase of a cycle. Kind code 3 is never taken.
- R9: `ad_out` reads 0 whenever `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| req_valid | input | 1 | A cycle request is presented |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 unused |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request can be taken on a tick |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Byte captured by the last fetch or read |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code-fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared-port output value |
| ad_oe | output | 1 | Shared-port output enable |
| ad_in | input | 8 | Shared-port input value |
| a_hi | output | 8 | High address byte |

## Verification
The assertions rely on three properties of the inputs:

- `osc_tick` is a single-clock pulse.
- `osc_tick` may arrive on any clock, including back to back.
- Request fields stay steady on the clock where the request is taken.

The stimulus raises the tick with a random gap of one to three clocks. It changes the request and `ad_in` only half a clock away from the active edge. It also holds valid requests, including unused kind codes, across the final phase so that back-to-back taking and rejection are both exercised.

// File: rtl/mxb_pkg.sv
// Package: shared cycle-kind encoding for the multiplexed bus generator.
// Assumes a 2-bit kind field supplied by the requester.
package mxb_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } bus_kind_e;
endpackage

// File: rtl/mxb_sequencer.sv
// Sequencer: takes requests, counts oscillator periods within a cycle and
// raises the end-of-cycle pulse. Assumes osc_tick is a one-clock pulse.
module mxb_sequencer
    import mxb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BUS_W      = 8,
    parameter int PH_W       = 4,
    parameter int FETCH_LAST = 5,
    parameter int DATA_LAST  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              busy,
    output bus_kind_e         kind,
    output logic [PH_W-1:0]   phase,
    output logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  wdata,
    output logic              done
);
    logic              busy_q;
    bus_kind_e         kind_q;
    logic [PH_W-1:0]   ph_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    logic              done_q;
    logic [PH_W-1:0]   last_ph;
    logic              at_last;
    logic              accept;

    // Final phase of the running cycle and the take condition.
    always_comb begin
        last_ph   = (kind_q == KIND_FETCH) ? PH_W'(FETCH_LAST) : PH_W'(DATA_LAST);
        at_last   = busy_q && (ph_q == last_ph);
        req_ready = !busy_q || at_last;
        accept    = osc_tick && req_valid && req_ready
                    && (bus_kind_e'(req_kind) != KIND_NONE);
    end

    // Cycle state: take, advance on tick, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            kind_q  <= KIND_FETCH;
            ph_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= osc_tick && at_last;
            if (accept) begin
                busy_q  <= 1'b1;
                kind_q  <= bus_kind_e'(req_kind);
                ph_q    <= '0;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end else if (osc_tick && at_last) begin
                busy_q <= 1'b0;
                ph_q   <= '0;
            end else if (osc_tick && busy_q) begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign busy  = busy_q;
    assign kind  = kind_q;
    assign phase = ph_q;
    assign addr  = addr_q;
    assign wdata = wdata_q;
    assign done  = done_q;

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !osc_tick) |=> $stable(ph_q));
    // R8
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !osc_tick) |=> !busy_q);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/mxb_strobe_decode.sv
// Strobe decode: turns cycle kind and phase into the latch, fetch, read and
// write strobes. Assumes phase and kind come straight from registers.
module mxb_strobe_decode
    import mxb_pkg::*;
#(
    parameter int PH_W     = 4,
    parameter int ALE_PER  = 2,
    parameter int F_LO     = 3,
    parameter int F_HI     = 5,
    parameter int D_LO     = 5,
    parameter int D_HI     = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  bus_kind_e       kind,
    input  logic [PH_W-1:0] phase,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n
);
    logic in_fetch_win;
    logic in_data_win;

    // Phase windows for each strobe.
    always_comb begin
        in_fetch_win = (phase >= PH_W'(F_LO)) && (phase <= PH_W'(F_HI));
        in_data_win  = (phase >= PH_W'(D_LO)) && (phase <= PH_W'(D_HI));
        ale    = busy && (phase < PH_W'(ALE_PER));
        psen_n = !(busy && (kind == KIND_FETCH) && in_fetch_win);
        rd_n   = !(busy && (kind == KIND_READ)  && in_data_win);
        wr_n   = !(busy && (kind == KIND_WRITE) && in_data_win);
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
    // R2
    ale_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));
endmodule

// File: rtl/mxb_port_mux.sv
// Port mux: drives the shared port with the low address or the write byte
// and captures fetched or read bytes. Assumes ad_in is steady at the tick.
module mxb_port_mux
    import mxb_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int PH_W     = 4,
    parameter int ADDR_ON  = 1,
    parameter int ADDR_OFF = 2,
    parameter int W_ON     = 4,
    parameter int W_OFF    = 11,
    parameter int F_SAMPLE = 5,
    parameter int D_SAMPLE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             busy,
    input  bus_kind_e        kind,
    input  logic [PH_W-1:0]  phase,
    input  logic [BUS_W-1:0] addr_lo,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic [BUS_W-1:0] rdata
);
    logic addr_win;
    logic wr_win;
    logic sample;

    // Select what the shared port carries this period.
    always_comb begin
        addr_win = busy && (phase >= PH_W'(ADDR_ON)) && (phase <= PH_W'(ADDR_OFF));
        wr_win   = busy && (kind == KIND_WRITE)
                   && (phase >= PH_W'(W_ON)) && (phase <= PH_W'(W_OFF));
        ad_oe    = addr_win || wr_win;
        ad_out   = addr_win ? addr_lo : (wr_win ? wdata : '0);
        sample   = osc_tick && busy
                   && (((kind == KIND_FETCH) && (phase == PH_W'(F_SAMPLE)))
                    || ((kind == KIND_READ)  && (phase == PH_W'(D_SAMPLE))));
    end

    // Capture the incoming byte at the end of the strobe-low window.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (sample) rdata <= ad_in;
    end

    // R9
    quiet_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0));
endmodule

// File: rtl/mxb_bus_gen.sv
// Top: multiplexed external bus cycle generator. Ties sequencer, strobe
// decode and port mux together; derives every phase position from the
// period counts. Assumes WD_HOLD <= ALE_TAIL and ADDR_HOLD <= FETCH_GAP.
module mxb_bus_gen
    import mxb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUS_W     = 8,
    parameter int ALE_PER   = 2,
    parameter int ADDR_LEAD = 1,
    parameter int ADDR_HOLD = 1,
    parameter int FETCH_GAP = 1,
    parameter int FSTB_W    = 3,
    parameter int DATA_GAP  = 3,
    parameter int DSTB_W    = 6,
    parameter int WD_LEAD   = 1,
    parameter int WD_HOLD   = 1,
    parameter int ALE_TAIL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [BUS_W-1:0]  rdata,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [ADDR_W-BUS_W-1:0] a_hi
);
    localparam int ADDR_ON    = ALE_PER - ADDR_LEAD;
    localparam int ADDR_OFF   = ALE_PER + ADDR_HOLD - 1;
    localparam int F_LO       = ALE_PER + FETCH_GAP;
    localparam int F_HI       = F_LO + FSTB_W - 1;
    localparam int FETCH_LAST = F_HI;
    localparam int D_LO       = ALE_PER + DATA_GAP;
    localparam int D_HI       = D_LO + DSTB_W - 1;
    localparam int DATA_LAST  = D_HI + ALE_TAIL;
    localparam int W_ON       = D_LO - WD_LEAD;
    localparam int W_OFF      = D_HI + WD_HOLD;
    localparam int PH_W       = $clog2(DATA_LAST + 1);

    logic              busy;
    bus_kind_e         kind;
    logic [PH_W-1:0]   phase;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;

    mxb_sequencer #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PH_W(PH_W),
        .FETCH_LAST(FETCH_LAST), .DATA_LAST(DATA_LAST)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy),
        .kind(kind), .phase(phase), .addr(addr), .wdata(wdata), .done(done)
    );

    mxb_strobe_decode #(
        .PH_W(PH_W), .ALE_PER(ALE_PER), .F_LO(F_LO), .F_HI(F_HI),
        .D_LO(D_LO), .D_HI(D_HI)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .busy(busy), .kind(kind), .phase(phase),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    mxb_port_mux #(
        .BUS_W(BUS_W), .PH_W(PH_W), .ADDR_ON(ADDR_ON), .ADDR_OFF(ADDR_OFF),
        .W_ON(W_ON), .W_OFF(W_OFF), .F_SAMPLE(F_HI), .D_SAMPLE(D_HI)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .busy(busy),
        .kind(kind), .phase(phase), .addr_lo(addr[BUS_W-1:0]),
        .wdata(wdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .rdata(rdata)
    );

    assign a_hi = addr[ADDR_W-1:BUS_W];

    // R5
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R6
    wdata_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ad_oe);
endmodule

// File: tb/mxb_bus_gen_test.sv
// Bench: reference model of the bus cycle built from the requirements,
// random requests and tick gaps with directed corner cases.
module mxb_bus_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'd0;
    logic [7:0]  req_wdata = 8'd0;
    logic [7:0]  ad_in = 8'd0;
    logic        req_ready, done, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  rdata, ad_out, a_hi;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit over    = 0;

    // Reference model state
    bit       m_busy = 0;
    int       m_kind = 0;
    int       m_ph   = 0;
    bit [7:0] m_lo = 0, m_hi = 0, m_wd = 0, m_rdata = 0;
    bit       m_done = 0;

    mxb_bus_gen uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
    );

    always #10 clk = ~clk;

    function automatic int last_of(int k);
        return (k == 0) ? 5 : 11;
    endfunction

    function automatic bit exp_ready();
        return !m_busy || (m_ph == last_of(m_kind));
    endfunction

    task automatic chk(bit ok, string tag, int got, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Reference model update on each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_ph <= 0; m_kind <= 0; m_hi <= 0; m_lo <= 0;
            m_wd <= 0; m_rdata <= 0; m_done <= 0;
        end else begin
            m_done <= osc_tick && m_busy && (m_ph == last_of(m_kind));
            if (osc_tick && m_busy &&
                ((m_kind == 0 && m_ph == 5) || (m_kind == 1 && m_ph == 10)))
                m_rdata <= ad_in;
            if (osc_tick && req_valid && exp_ready() && req_kind != 2'd3) begin
                m_busy <= 1; m_ph <= 0; m_kind <= int'(req_kind);
                m_hi <= req_addr[15:8]; m_lo <= req_addr[7:0]; m_wd <= req_wdata;
            end else if (osc_tick && m_busy && m_ph == last_of(m_kind)) begin
                m_busy <= 0; m_ph <= 0;
            end else if (osc_tick && m_busy) begin
                m_ph <= m_ph + 1;
            end
        end
    end

    // Output checks half a clock after each edge.
    always @(negedge clk) begin
        if (rst_n && !over) begin
            bit e_ale, e_psen, e_rd, e_wr, e_oe;
            bit [7:0] e_out;
            e_ale  = m_busy && m_ph < 2;
            e_psen = !(m_busy && m_kind == 0 && m_ph >= 3 && m_ph <= 5);
            e_rd   = !(m_busy && m_kind == 1 && m_ph >= 5 && m_ph <= 10);
            e_wr   = !(m_busy && m_kind == 2 && m_ph >= 5 && m_ph <= 10);
            e_oe   = m_busy && ((m_ph >= 1 && m_ph <= 2) ||
                                (m_kind == 2 && m_ph >= 4 && m_ph <= 11));
            e_out  = !e_oe ? 8'h00 : (m_ph <= 2 ? m_lo : m_wd);
            chk(ale == e_ale, "R2 ale", ale, e_ale);
            chk(psen_n == e_psen, "R4 psen_n", psen_n, e_psen);
            chk(rd_n == e_rd, "R5 rd_n", rd_n, e_rd);
            chk(wr_n == e_wr, "R6 wr_n", wr_n, e_wr);
            if (m_busy && m_ph <= 2)
                chk(ad_oe == e_oe && ad_out == e_out, "R3 port address",
                    {ad_oe, ad_out}, {e_oe, e_out});
            else if (m_busy && m_kind == 2)
                chk(ad_oe == e_oe && ad_out == e_out, "R6 port write byte",
                    {ad_oe, ad_out}, {e_oe, e_out});
            else
                chk(ad_oe == 1'b0, "R5 port released", ad_oe, 0);
            if (!ad_oe) chk(ad_out == 8'h00, "R9 quiet port", ad_out, 0);
            chk(a_hi == m_hi, "R3 a_hi", a_hi, m_hi);
            chk(req_ready == exp_ready(), "R8 req_ready", req_ready, exp_ready());
            chk(done == m_done, "R7 done", done, m_done);
            chk(rdata == m_rdata, "R7 rdata", rdata, m_rdata);
            if (!m_busy)
                chk(ale == 0 && psen_n && rd_n && wr_n && !ad_oe && req_ready,
                    "R1 idle", {ale, psen_n, rd_n, wr_n, ad_oe, req_ready}, 6'b011101);
        end
    end

    // Tick and ad_in generation, changed away from the edge.
    always @(negedge clk) begin
        osc_tick <= ($urandom_range(0, 2) == 0) || (cyc % 3 == 0);
        ad_in    <= 8'($urandom);
        cyc      <= cyc + 1;
    end

    task automatic summary();
        if (!over) begin
            over = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ale == 0 && psen_n && rd_n && wr_n && !ad_oe && ad_out == 0 && !done
            && req_ready, "R1 reset", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
        rst_n = 1'b1;
        // R8 unused kind code held across many ticks: nothing starts
        req_valid = 1; req_kind = 2'd3; req_addr = 16'hBEEF;
        repeat (40) @(negedge clk);
        chk(ale == 0 && a_hi == 8'h00, "R8 kind 3 rejected", {ale, a_hi}, 0);
        req_valid = 0;
        repeat (5) @(negedge clk);
        // R4 back-to-back fetches with request held
        req_valid = 1; req_kind = 2'd0; req_addr = 16'h12A5;
        repeat (80) @(negedge clk);
        // R5 back-to-back reads, R6 writes
        req_kind = 2'd1; req_addr = 16'hFF00;
        repeat (120) @(negedge clk);
        req_kind = 2'd2; req_addr = 16'h00FF; req_wdata = 8'h5A;
        repeat (120) @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 3) != 0);
            req_kind  = 2'($urandom_range(0, 3));
            req_addr  = 16'($urandom);
            req_wdata = 8'($urandom);
            @(negedge clk);
        end
        req_valid = 0;
        repeat (60) @(negedge clk);
        summary();
    end
endmodule